// File: doc/BRIEF.md
# SIMD Multiply Result Merge Unit

This block sits behind a 64-bit partitioned SIMD multiplier and turns its two result buses into the final register value. The multiplier delivers, for every lane, a low-half chunk and a high-half chunk of the lane product on separate 64-bit buses. Depending on the requested flavour, the merge unit returns:

- the low halves (plain multiply);
- the high halves (multiply-high);
- full double-width products of either the lower or the upper half of the lanes (widening variants), built by placing each lane's high chunk directly above its low chunk.

For 8- and 16-bit lanes the high halves reach the merge unit one cycle after the low halves. The unit therefore holds the low half in a one-cycle stage, together with its opcode, lane width and tag, until the matching high half arrives. For 32- and 64-bit lanes both buses arrive in the same cycle and bypass that stage. Every result is registered once before it leaves on a 64-bit data output, a valid flag and a tag output.

Top module: `simd_mul_merge`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `out_data` and `out_tag` are all zero.
- R2: Opcode 2'b00 (plain multiply) returns the low bus unchanged at every lane width.
- R3: Opcode 2'b01 (multiply-high) returns the high bus unchanged at every lane width.
- R4: Opcode 2'b10 (widening, lower lanes) works as follows, for a lane width W below 64 with N = 64/W lanes. Lanes 0 to N/2-1 each give a 2W-bit product {high chunk, low chunk}, and the product of lane j is placed at bits [2W·j +: 2W]. Lane k of either bus occupies bits [W·k +: W]. For W = 64 the output is the low bus.
- R5: Opcode 2'b11 (widening, upper lanes) works like R4 but uses lanes N/2 to N-1. The product of lane N/2+j is placed at bits [2W·j +: 2W]. For W = 64 the output is the high bus.
- R6: Width code 2'b00 means 8-bit lanes and 2'b01 means 16-bit lanes. For these, `in_valid`, `in_op`, `in_width`, `in_tag` and `lo_data` are sampled at clock edge k, and `hi_data` at edge k+1. `out_valid` is high for exactly the one cycle after edge k+1.
- R7: Width code 2'b10 means 32-bit lanes and 2'b11 means 64-bit lanes. For these, both buses are sampled with `in_valid` at edge k, and `out_valid` is high for exactly the one cycle after edge k.
- R8: `out_tag` equals the `in_tag` sampled with the operation's low half.
- R9: 8- and 16-bit operations may be issued on consecutive cycles, and each gives its own correct result one cycle after the previous one.
- R10: If a 32- or 64-bit operation is issued at the same edge at which a pending 8/16-bit operation takes its high half, the pending operation completes and the wider one is discarded.
- R11: `out_valid` is low in every cycle that follows an edge at which no operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Low half and control of a new operation are present |
| in_op | input | 2 | Flavour: 00 multiply, 01 multiply-high, 10 widen lower lanes, 11 widen upper lanes |
| in_width | input | 2 | Lane width: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| in_tag | input | TAG_W | Tag carried to the result |
| lo_data | input | 64 | Low-half result bus |
| hi_data | input | 64 | High-half result bus |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Merged result word |
| out_tag | output | TAG_W | Tag of the result |

## Verification
The buses carry byte patterns in which every byte names both its lane and its bus (low byte k = 0x80+k, high byte k = 0x90+k). A misplaced chunk, a swapped lane half or a wrong bus therefore shows up as a distinct wrong value. Every flavour is tried at all four lane widths. This separates the 8/16/32/64-bit interleave paths from one another and from the pass-through flavours. Two back-to-back narrow operations with different high buses and tags show that the delay stage keeps each low half apart from the next one. A wide issue that collides with a pending narrow completion shows which of the two wins, and that the loser produces no valid cycle.

// File: rtl/simd_mul_merge.sv
module simd_mul_merge #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [1:0]       in_width,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [63:0]      lo_data,
  input  logic [63:0]      hi_data,
  output logic             out_valid,
  output logic [63:0]      out_data,
  output logic [TAG_W-1:0] out_tag
);

  logic             p_valid;
  logic [1:0]       p_op, p_width;
  logic [TAG_W-1:0] p_tag;
  logic [63:0]      p_lo;

  wire narrow_in = in_valid & ~in_width[1];
  wire wide_in   = in_valid &  in_width[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_op    <= '0;
      p_width <= '0;
      p_tag   <= '0;
      p_lo    <= '0;
    end else begin
      p_valid <= narrow_in;
      if (narrow_in) begin
        p_op    <= in_op;
        p_width <= in_width;
        p_tag   <= in_tag;
        p_lo    <= lo_data;
      end
    end
  end

  wire [1:0]       m_op    = p_valid ? p_op    : in_op;
  wire [1:0]       m_width = p_valid ? p_width : in_width;
  wire [TAG_W-1:0] m_tag   = p_valid ? p_tag   : in_tag;
  wire [63:0]      m_lo    = p_valid ? p_lo    : lo_data;
  wire             m_fire  = p_valid | wide_in;

  logic [63:0] merged;

  always_comb begin
    merged = '0;
    case (m_op)
      2'b00: merged = m_lo;
      2'b01: merged = hi_data;
      default: begin
        case (m_width)
          2'b00: begin
            for (int j = 0; j < 4; j++) begin
              merged[16*j +: 16] = m_op[0]
                ? {hi_data[8*(j+4) +: 8], m_lo[8*(j+4) +: 8]}
                : {hi_data[8*j +: 8],     m_lo[8*j +: 8]};
            end
          end
          2'b01: begin
            for (int j = 0; j < 2; j++) begin
              merged[32*j +: 32] = m_op[0]
                ? {hi_data[16*(j+2) +: 16], m_lo[16*(j+2) +: 16]}
                : {hi_data[16*j +: 16],     m_lo[16*j +: 16]};
            end
          end
          2'b10: merged = m_op[0] ? {hi_data[63:32], m_lo[63:32]}
                                  : {hi_data[31:0],  m_lo[31:0]};
          default: merged = m_op[0] ? hi_data : m_lo;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= m_fire;
      if (m_fire) begin
        out_data <= merged;
        out_tag  <= m_tag;
      end
    end
  end

endmodule

module simd_mul_merge_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic [1:0]       in_width,
  input logic [TAG_W-1:0] in_tag,
  input logic [63:0]      lo_data,
  input logic [63:0]      hi_data,
  input logic             out_valid,
  input logic [63:0]      out_data,
  input logic [TAG_W-1:0] out_tag
);

  // R6
  narrow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_width[1]) |=> ##1 out_valid);

  // R7
  wide_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_width[1] && !($past(in_valid) && !$past(in_width[1])))
      |=> out_valid);

  // R8
  narrow_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_width[1]) |=> ##1 (out_tag == $past(in_tag, 2)));

  // R2
  wide_mul_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_width[1] && in_op == 2'b00 &&
     !($past(in_valid) && !$past(in_width[1])))
      |=> (out_data == $past(lo_data)));

  // R11
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) || $past(in_valid, 2)));

endmodule

bind simd_mul_merge simd_mul_merge_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_width(in_width), .in_tag(in_tag), .lo_data(lo_data),
  .hi_data(hi_data), .out_valid(out_valid), .out_data(out_data),
  .out_tag(out_tag)
);

// File: tb/simd_mul_merge_test.sv
module simd_mul_merge_test;
  localparam int TAG_W = 4;
  localparam logic [63:0] LO = 64'h8786_8584_8382_8180;
  localparam logic [63:0] HI = 64'h9796_9594_9392_9190;

  // {op, width, expected}
  localparam logic [67:0] VEC [16] = '{
    {2'b00, 2'b00, LO}, {2'b00, 2'b01, LO}, {2'b00, 2'b10, LO}, {2'b00, 2'b11, LO},
    {2'b01, 2'b00, HI}, {2'b01, 2'b01, HI}, {2'b01, 2'b10, HI}, {2'b01, 2'b11, HI},
    {2'b10, 2'b00, 64'h9383_9282_9181_9080},
    {2'b10, 2'b01, 64'h9392_8382_9190_8180},
    {2'b10, 2'b10, 64'h9392_9190_8382_8180},
    {2'b10, 2'b11, LO},
    {2'b11, 2'b00, 64'h9787_9686_9585_9484},
    {2'b11, 2'b01, 64'h9796_8786_9594_8584},
    {2'b11, 2'b10, 64'h9796_9594_8786_8584},
    {2'b11, 2'b11, HI}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [1:0]       in_op = '0, in_width = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [63:0]      lo_data = '0, hi_data = '0;
  logic             out_valid;
  logic [63:0]      out_data;
  logic [TAG_W-1:0] out_tag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  simd_mul_merge #(.TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_width(in_width), .in_tag(in_tag), .lo_data(lo_data),
    .hi_data(hi_data), .out_valid(out_valid), .out_data(out_data),
    .out_tag(out_tag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [1:0] w,
                        input logic [TAG_W-1:0] tag, input logic [63:0] exp,
                        input string req);
    in_valid = 1'b1; in_op = op; in_width = w; in_tag = tag; lo_data = LO;
    hi_data = w[1] ? HI : 64'h0;
    step();
    in_valid = 1'b0; lo_data = '0;
    if (!w[1]) begin
      hi_data = HI;
      check({req, " pre-valid"}, {63'd0, out_valid}, 64'd0);
      step();
    end
    hi_data = '0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " data"}, out_data, exp);
    check("R8 tag", {60'd0, out_tag}, {60'd0, tag});
    step();
    check("R11 idle", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    step(); step();
    check("R1 data", out_data, 64'd0);
    check("R1 tag", {60'd0, out_tag}, 64'd0);
    rst_n = 1'b1;
    step();
    check("R1 after reset", {63'd0, out_valid}, 64'd0);

    // R2 R3 R4 R5 R6 R7 via table
    for (int i = 0; i < 16; i++) begin
      run_op(VEC[i][67:66], VEC[i][65:64], TAG_W'(i), VEC[i][63:0],
             VEC[i][65] ? "R2-R5/R7" : "R2-R5/R6");
    end

    // R9: back-to-back narrow multiply-high
    in_valid = 1'b1; in_op = 2'b01; in_width = 2'b01; in_tag = 4'd5; lo_data = LO;
    step();
    in_tag = 4'd6; in_width = 2'b00; hi_data = 64'hAAAA_AAAA_AAAA_AAAA;
    step();
    in_valid = 1'b0;
    check("R9 first data", out_data, 64'hAAAA_AAAA_AAAA_AAAA);
    check("R9 first tag", {60'd0, out_tag}, 64'd5);
    hi_data = 64'hBBBB_BBBB_BBBB_BBBB;
    step();
    check("R9 second valid", {63'd0, out_valid}, 64'd1);
    check("R9 second data", out_data, 64'hBBBB_BBBB_BBBB_BBBB);
    check("R9 second tag", {60'd0, out_tag}, 64'd6);
    hi_data = '0;
    step();
    check("R11 after burst", {63'd0, out_valid}, 64'd0);

    // R10: wide issue collides with narrow completion
    in_valid = 1'b1; in_op = 2'b00; in_width = 2'b00; in_tag = 4'd3;
    lo_data = 64'h0123_4567_89AB_CDEF;
    step();
    in_width = 2'b10; in_tag = 4'd9; lo_data = 64'hDEAD_BEEF_DEAD_BEEF; hi_data = HI;
    step();
    in_valid = 1'b0; lo_data = '0; hi_data = '0;
    check("R10 narrow wins data", out_data, 64'h0123_4567_89AB_CDEF);
    check("R10 narrow wins tag", {60'd0, out_tag}, 64'd3);
    step();
    check("R10 wide dropped", {63'd0, out_valid}, 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule